// File: doc/BRIEF.md
# Range-Rule Address Interleave Decoder

This block resolves a physical address to the node or logical memory channel that owns it, then turns the logical channel into a physical one. It holds a small ordered table of range rules. Each rule carries an enable, an exclusive upper limit, a way-hash mode and a packed list of eight targets. The first enabled rule whose range contains the address is chosen. Its mode turns address bits into a 3-bit way, and the way picks one of the eight list entries.

The picked 2-bit target is reported three ways. It is reported raw as the logical channel. It is decoded as a node number. It is also passed through a per-target remap code that handles one-hot channel steering, mirrored pairs and sparing, unless lockstep is set. Rules are written one whole rule per cycle through a write port. Queries use a valid/ready handshake and return after a fixed two-cycle pipeline. Each answer carries a hit flag and the number of distinct targets in the chosen rule's list.

Top module: `addr_interleave_decoder`

## Requirements
- R1: Rules are tested from index 0 upward, and the lowest-index match wins. Rule i covers [L(i-1), L(i)), where L(-1) = 0 and L is the rule limit. The lower bound comes from the previous rule's limit even when that rule is disabled. A match needs the rule's enable set.
- R2: In mode 0 the way is address bits [8:6].
- R3: In mode 1 the way is address bits [8:6] XOR bits [18:16].
- R4: In mode 2 the way's bit 2 is address bit 6. Its bits [1:0] are (address bits [39:6]) modulo 3.
- R5: The list holds way k in bits [4k+3:4k]. The target is the low two bits of that nibble; the upper two bits are ignored.
- R6: Target code 1 reports node 0 and code 2 reports node 1, each with `rspNodeValid` = 1. Codes 0 and 3 give `rspNodeValid` = 0 and `rspNode` = 0.
- R7: On a hit, `rspWays` is the number of distinct 2-bit targets among the eight list entries (1 to 4).
- R8: The remap code for target t sits in bits [3t+2:3t] of `chanMapRd` on reads and of `chanMapWr` on writes. Codes 1, 2 and 4 give physical channels 0, 1 and 2. Codes 0 and 7 leave the target unchanged.
- R9: Code 3 (mirrored pair) on a read gives channel address bit 24 XOR bit 12 XOR bit 6. On a write it leaves the target unchanged.
- R10: Code 5 gives physical channel 0 and code 6 gives physical channel 1.
- R11: While `lockstep` is 1, `rspPhyChan` equals the target and the remap codes have no effect.
- R12: If no rule matches, or the matched rule has mode 3, `rspHit` = 0 and every other response field is 0.
- R13: A query is accepted when `reqValid` and `reqReady` are both 1, and its answer appears with `rspValid` two clock edges later. `reqReady` is 0 in any cycle with `cfgWe` = 1. The rule write takes effect at that edge, so a query held over it is decoded against the new rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Rule write strobe |
| cfgIdx | input | 2 | Rule index written |
| cfgEn | input | 1 | Enable of written rule |
| cfgMode | input | 2 | Way-hash mode of written rule |
| cfgLimit | input | 40 | Exclusive upper limit of written rule |
| cfgList | input | 32 | Eight 4-bit target nibbles |
| lockstep | input | 1 | Bypass the channel remap |
| chanMapRd | input | 12 | Four 3-bit remap codes for reads |
| chanMapWr | input | 12 | Four 3-bit remap codes for writes |
| reqValid | input | 1 | Query valid |
| reqReady | output | 1 | Query accepted this cycle |
| reqAddr | input | 40 | Query address |
| reqWrite | input | 1 | 1 = write query, 0 = read |
| rspValid | output | 1 | Answer valid |
| rspHit | output | 1 | Address matched a usable rule |
| rspTarget | output | 2 | Logical target from the list |
| rspNodeValid | output | 1 | Target decodes to a node |
| rspNode | output | 1 | Node number |
| rspPhyChan | output | 2 | Physical channel after remap |
| rspWays | output | 3 | Distinct targets in the chosen list |

## Verification
A rule write and a query can land in the same cycle. The bench starts a one-cycle rule write and a query on the same clock edge. The rewritten rule is the one that covers the queried address, so decoding against the old or new contents gives visibly different answers. The behavioural model refuses the query while the write strobe is high, applies the write, and then expects the query to be accepted one cycle later and answered from the new rule. The bench also checks that `reqReady` is low in every write cycle.

// File: rtl/addrq_pkg.sv
package addrq_pkg;

  typedef enum logic [1:0] {
    MODE_LOW = 2'd0,
    MODE_XOR = 2'd1,
    MODE_TRI = 2'd2,
    MODE_RSV = 2'd3
  } hashMode_e;

  typedef struct packed {
    logic cfgLoad;
    logic s1Load;
    logic s2Load;
  } ctlStrobes_t;

  function automatic logic [1:0] remapChan(input logic [2:0] code,
                                           input logic [1:0] tgt,
                                           input logic       isWrite,
                                           input logic       mirrorBit);
    logic [1:0] ch;
    case (code)
      3'd1: ch = 2'd0;
      3'd2: ch = 2'd1;
      3'd4: ch = 2'd2;
      3'd3: ch = isWrite ? tgt : {1'b0, mirrorBit};
      3'd5: ch = 2'd0;
      3'd6: ch = 2'd1;
      default: ch = tgt;
    endcase
    return ch;
  endfunction

endpackage

// File: rtl/addrq_ctrl.sv
module addrq_ctrl
  import addrq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        cfgWe,
  output logic        reqReady,
  output ctlStrobes_t stb,
  output logic        rspValid
);

  logic s1Valid;

  assign reqReady    = !cfgWe;
  assign stb.cfgLoad = cfgWe;
  assign stb.s1Load  = reqValid && !cfgWe;
  assign stb.s2Load  = s1Valid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      rspValid <= 1'b0;
    end else begin
      s1Valid  <= stb.s1Load;
      rspValid <= s1Valid;
    end
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(s1Valid)); // R13
  AST_STALL_ON_CFG: assert property (@(posedge clk) disable iff (!rstN)
    s1Valid |-> ($past(reqValid) && !$past(cfgWe))); // R13

endmodule

// File: rtl/addrq_dp.sv
module addrq_dp
  import addrq_pkg::*;
#(
  parameter int ADDR_W    = 40,
  parameter int NUM_RULES = 4,
  parameter int IDX_W     = 2,
  parameter int NUM_WAYS  = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobes_t           stb,
  input  logic [IDX_W-1:0]      cfgIdx,
  input  logic                  cfgEn,
  input  logic [1:0]            cfgMode,
  input  logic [ADDR_W-1:0]     cfgLimit,
  input  logic [4*NUM_WAYS-1:0] cfgList,
  input  logic                  lockstep,
  input  logic [11:0]           chanMapRd,
  input  logic [11:0]           chanMapWr,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic                  reqWrite,
  output logic                  rspHit,
  output logic [1:0]            rspTarget,
  output logic                  rspNodeValid,
  output logic                  rspNode,
  output logic [1:0]            rspPhyChan,
  output logic [2:0]            rspWays
);

  localparam int TGT_W  = 2 * NUM_WAYS;
  localparam int MOD_W  = ADDR_W - 6;
  localparam int NPAIR  = (MOD_W + 1) / 2;
  localparam int SUM_W  = $clog2(3 * NPAIR + 1);

  // rule table: only the 2-bit target of each nibble is kept
  logic              ruleEn    [NUM_RULES];
  hashMode_e         ruleMode  [NUM_RULES];
  logic [ADDR_W-1:0] ruleLimit [NUM_RULES];
  logic [TGT_W-1:0]  ruleTgts  [NUM_RULES];

  logic [TGT_W-1:0] cfgTgts;
  logic [TGT_W-1:0] cfgListUnused;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_pack
    assign cfgTgts[2*w +: 2]       = cfgList[4*w +: 2];
    assign cfgListUnused[2*w +: 2] = cfgList[4*w+2 +: 2];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_RULES; i++) begin
        ruleEn[i]    <= 1'b0;
        ruleMode[i]  <= MODE_LOW;
        ruleLimit[i] <= '0;
        ruleTgts[i]  <= '0;
      end
    end else if (stb.cfgLoad) begin
      for (int i = 0; i < NUM_RULES; i++) begin
        if (IDX_W'(i) == cfgIdx) begin
          ruleEn[i]    <= cfgEn;
          ruleMode[i]  <= hashMode_e'(cfgMode);
          ruleLimit[i] <= cfgLimit;
          ruleTgts[i]  <= cfgTgts;
        end
      end
    end
  end

  // stage 1: range match, priority pick, modulo-3 fold
  logic [NUM_RULES-1:0] hitVec;

  for (genvar g = 0; g < NUM_RULES; g++) begin : g_match
    logic [ADDR_W-1:0] lowBound;
    if (g == 0) begin : g_first
      assign lowBound = '0;
    end else begin : g_rest
      assign lowBound = ruleLimit[g-1];
    end
    assign hitVec[g] = ruleEn[g] && (reqAddr >= lowBound) && (reqAddr < ruleLimit[g]);
  end

  logic             selHit;
  hashMode_e        selMode;
  logic [TGT_W-1:0] selTgts;

  always_comb begin
    selHit  = 1'b0;
    selMode = MODE_LOW;
    selTgts = '0;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        selHit  = 1'b1;
        selMode = ruleMode[i];
        selTgts = ruleTgts[i];
      end
    end
  end

  function automatic logic [1:0] mod3Fold(input logic [MOD_W-1:0] v);
    logic [2*NPAIR-1:0] pv;
    logic [SUM_W-1:0]   acc;
    pv  = (2*NPAIR)'(v);
    acc = '0;
    for (int k = 0; k < NPAIR; k++) acc = acc + SUM_W'(pv[2*k +: 2]);
    return 2'(acc % SUM_W'(3));
  endfunction

  logic [1:0] mod3Comb;
  assign mod3Comb = mod3Fold(reqAddr[ADDR_W-1:6]);

  logic             s1Hit;
  hashMode_e        s1Mode;
  logic [TGT_W-1:0] s1Tgts;
  logic [2:0]       s1WayLow;
  logic [2:0]       s1WayXor;
  logic             s1Mirror;
  logic             s1Write;
  logic [1:0]       s1Mod3;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Hit    <= 1'b0;
      s1Mode   <= MODE_LOW;
      s1Tgts   <= '0;
      s1WayLow <= '0;
      s1WayXor <= '0;
      s1Mirror <= 1'b0;
      s1Write  <= 1'b0;
      s1Mod3   <= '0;
    end else if (stb.s1Load) begin
      s1Hit    <= selHit;
      s1Mode   <= selMode;
      s1Tgts   <= selTgts;
      s1WayLow <= reqAddr[8:6];
      s1WayXor <= reqAddr[18:16];
      s1Mirror <= reqAddr[24] ^ reqAddr[12] ^ reqAddr[6];
      s1Write  <= reqWrite;
      s1Mod3   <= mod3Comb;
    end
  end

  AST_MOD3_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    s1Mod3 != 2'd3); // R4

  // stage 2: way, target, node, distinct count, remap
  logic [2:0] way;
  always_comb begin
    case (s1Mode)
      MODE_LOW: way = s1WayLow;
      MODE_XOR: way = s1WayLow ^ s1WayXor;
      MODE_TRI: way = {s1WayLow[0], s1Mod3};
      default:  way = 3'd0;
    endcase
  end

  logic       useHit;
  logic [1:0] tgt;
  logic [3:0] present;
  logic [2:0] mapCode;
  logic [1:0] phyChan;

  assign useHit = s1Hit && (s1Mode != MODE_RSV);
  assign tgt    = s1Tgts[{way, 1'b0} +: 2];

  always_comb begin
    present = '0;
    for (int k = 0; k < NUM_WAYS; k++) present[s1Tgts[2*k +: 2]] = 1'b1;
  end

  assign mapCode = s1Write ? chanMapWr[3*tgt +: 3] : chanMapRd[3*tgt +: 3];
  assign phyChan = lockstep ? tgt : remapChan(mapCode, tgt, s1Write, s1Mirror);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspHit       <= 1'b0;
      rspTarget    <= '0;
      rspNodeValid <= 1'b0;
      rspNode      <= 1'b0;
      rspPhyChan   <= '0;
      rspWays      <= '0;
    end else if (stb.s2Load) begin
      rspHit       <= useHit;
      rspTarget    <= useHit ? tgt : 2'd0;
      rspNodeValid <= useHit && (tgt == 2'd1 || tgt == 2'd2);
      rspNode      <= useHit && (tgt == 2'd2);
      rspPhyChan   <= useHit ? phyChan : 2'd0;
      rspWays      <= useHit ? 3'($countones(present)) : 3'd0;
    end
  end

endmodule

// File: rtl/addr_interleave_decoder.sv
module addr_interleave_decoder
  import addrq_pkg::*;
#(
  parameter int ADDR_W    = 40,
  parameter int NUM_RULES = 4,
  parameter int NUM_WAYS  = 8,
  localparam int IDX_W    = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1,
  localparam int LIST_W   = 4 * NUM_WAYS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic              cfgEn,
  input  logic [1:0]        cfgMode,
  input  logic [ADDR_W-1:0] cfgLimit,
  input  logic [LIST_W-1:0] cfgList,
  input  logic              lockstep,
  input  logic [11:0]       chanMapRd,
  input  logic [11:0]       chanMapWr,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  output logic              rspValid,
  output logic              rspHit,
  output logic [1:0]        rspTarget,
  output logic              rspNodeValid,
  output logic              rspNode,
  output logic [1:0]        rspPhyChan,
  output logic [2:0]        rspWays
);

  ctlStrobes_t stb;

  addrq_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .cfgWe    (cfgWe),
    .reqReady (reqReady),
    .stb      (stb),
    .rspValid (rspValid)
  );

  addrq_dp #(
    .ADDR_W    (ADDR_W),
    .NUM_RULES (NUM_RULES),
    .IDX_W     (IDX_W),
    .NUM_WAYS  (NUM_WAYS)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .cfgIdx       (cfgIdx),
    .cfgEn        (cfgEn),
    .cfgMode      (cfgMode),
    .cfgLimit     (cfgLimit),
    .cfgList      (cfgList),
    .lockstep     (lockstep),
    .chanMapRd    (chanMapRd),
    .chanMapWr    (chanMapWr),
    .reqAddr      (reqAddr),
    .reqWrite     (reqWrite),
    .rspHit       (rspHit),
    .rspTarget    (rspTarget),
    .rspNodeValid (rspNodeValid),
    .rspNode      (rspNode),
    .rspPhyChan   (rspPhyChan),
    .rspWays      (rspWays)
  );

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (rspTarget == 2'd0 && !rspNodeValid && !rspNode
                               && rspPhyChan == 2'd0 && rspWays == 3'd0)); // R12
  AST_NODE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspNodeValid) |-> (rspHit && rspTarget != 2'd0 && rspTarget != 2'd3)); // R6
  AST_WAYS_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspHit) |-> (rspWays != 3'd0 && rspWays <= 3'd4)); // R7
  AST_LOCKSTEP_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspHit && $past(lockstep)) |-> (rspPhyChan == rspTarget)); // R11

endmodule

// File: tb/tb_addr_interleave_decoder.sv
module tb_addr_interleave_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgIdx = '0;
  logic        cfgEn = 1'b0;
  logic [1:0]  cfgMode = '0;
  logic [39:0] cfgLimit = '0;
  logic [31:0] cfgList = '0;
  logic        lockstep = 1'b0;
  logic [11:0] chanMapRd = '0;
  logic [11:0] chanMapWr = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [39:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic        rspValid, rspHit, rspNodeValid, rspNode;
  logic [1:0]  rspTarget, rspPhyChan;
  logic [2:0]  rspWays;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_interleave_decoder dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgEn(cfgEn),
    .cfgMode(cfgMode), .cfgLimit(cfgLimit), .cfgList(cfgList), .lockstep(lockstep),
    .chanMapRd(chanMapRd), .chanMapWr(chanMapWr), .reqValid(reqValid),
    .reqReady(reqReady), .reqAddr(reqAddr), .reqWrite(reqWrite), .rspValid(rspValid),
    .rspHit(rspHit), .rspTarget(rspTarget), .rspNodeValid(rspNodeValid),
    .rspNode(rspNode), .rspPhyChan(rspPhyChan), .rspWays(rspWays)
  );

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  string curTag = "R13";

  // behavioural rule model
  bit          mEn   [4];
  int unsigned mMode [4];
  logic [39:0] mLim  [4];
  logic [31:0] mList [4];

  typedef struct {
    bit       v;
    bit [9:0] fields;
    string    tag;
  } expItem_t;

  expItem_t pipe0, pipe1;

  function automatic bit [9:0] refDecode(logic [39:0] a, bit wr);
    logic [39:0]     base = '0;
    int              hitIdx = -1;
    int unsigned     way, tgt, code, phy, ways;
    longint unsigned lineIdx;
    bit              seen [4];
    bit              nv, nd;
    for (int i = 0; i < 4; i++) begin
      if (mEn[i] && a >= base && a < mLim[i]) begin
        hitIdx = i;
        break;
      end
      base = mLim[i];
    end
    if (hitIdx < 0 || mMode[hitIdx] == 3) return 10'd0;
    lineIdx = longint'(a[39:6]);
    case (mMode[hitIdx])
      0: way = a[8:6];
      1: way = a[8:6] ^ a[18:16];
      default: way = (a[6] ? 4 : 0) + int'(lineIdx % 3);
    endcase
    tgt = (mList[hitIdx] >> (way * 4)) & 3;
    nv = (tgt == 1 || tgt == 2);
    nd = (tgt == 2);
    ways = 0;
    for (int k = 0; k < 4; k++) seen[k] = 0;
    for (int k = 0; k < 8; k++) seen[(mList[hitIdx] >> (k * 4)) & 3] = 1;
    for (int k = 0; k < 4; k++) if (seen[k]) ways++;
    code = wr ? ((chanMapWr >> (tgt * 3)) & 7) : ((chanMapRd >> (tgt * 3)) & 7);
    if (lockstep) phy = tgt;
    else case (code)
      1: phy = 0;
      2: phy = 1;
      4: phy = 2;
      3: phy = wr ? tgt : (a[24] ^ a[12] ^ a[6]);
      5: phy = 0;
      6: phy = 1;
      default: phy = tgt;
    endcase
    return {1'b1, 2'(tgt), nv, nd, 2'(phy), 3'(ways)};
  endfunction

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      cycles++;
      if (cycles > WATCHDOG) begin
        errors++;
        $display("FAIL watchdog R13: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
        finishRun();
      end
      if (pipe1.v || rspValid) begin
        checks++;
        if (rspValid !== pipe1.v ||
            (pipe1.v && {rspHit, rspTarget, rspNodeValid, rspNode, rspPhyChan, rspWays} !== pipe1.fields)) begin
          errors++;
          $display("FAIL %s: actual v=%0b f=%03h expected v=%0b f=%03h", pipe1.v ? pipe1.tag : "R13",
                   rspValid, {rspHit, rspTarget, rspNodeValid, rspNode, rspPhyChan, rspWays},
                   pipe1.v, pipe1.fields);
        end
      end
      if (cfgWe) begin
        checks++;
        if (reqReady !== 1'b0) begin
          errors++;
          $display("FAIL R13 ready during rule write: actual=%0b expected=0", reqReady);
        end
      end
      pipe1 = pipe0;
      pipe0.v = 0;
      pipe0.fields = '0;
      pipe0.tag = curTag;
      if (reqValid && !cfgWe) begin
        pipe0.v = 1;
        pipe0.fields = refDecode(reqAddr, reqWrite);
      end
      if (cfgWe) begin
        mEn[cfgIdx]   = cfgEn;
        mMode[cfgIdx] = cfgMode;
        mLim[cfgIdx]  = cfgLimit;
        mList[cfgIdx] = cfgList;
      end
    end
  end

  // tasks are entered one time unit after a rising edge
  task automatic writeRule(int idx, bit en, int mode, logic [39:0] lim, logic [31:0] lst);
    cfgWe = 1; cfgIdx = 2'(idx); cfgEn = en; cfgMode = 2'(mode);
    cfgLimit = lim; cfgList = lst;
    @(posedge clk); #1;
    cfgWe = 0;
  endtask

  task automatic sendReq(logic [39:0] a, bit wr);
    reqValid = 1; reqAddr = a; reqWrite = wr;
    do @(posedge clk); while (!reqReady);
    #1;
    reqValid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [39:0] rndIn(logic [39:0] lo, logic [39:0] hi);
    longint unsigned span = longint'(hi - lo);
    longint unsigned r = {32'($urandom()), 32'($urandom())};
    return lo + 40'(r % span);
  endfunction

  initial begin
    for (int i = 0; i < 4; i++) begin mEn[i] = 0; mMode[i] = 0; mLim[i] = '0; mList[i] = '0; end
    pipe0.v = 0; pipe0.fields = '0; pipe0.tag = "R13";
    pipe1 = pipe0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    checks++;
    if (rspValid !== 1'b0 || reqReady !== 1'b1) begin
      errors++;
      $display("FAIL R13 reset: actual v=%0b rdy=%0b expected v=0 rdy=1", rspValid, reqReady);
    end
    @(posedge clk); #1;

    chanMapRd = {3'd3, 3'd4, 3'd2, 3'd1};
    chanMapWr = {3'd0, 3'd3, 3'd6, 3'd5};
    writeRule(0, 1, 0, 40'h00_1000_0000, 32'h3210_3210);
    writeRule(1, 0, 1, 40'h00_2000_0000, 32'h1111_1111);
    writeRule(2, 1, 1, 40'h00_4000_0000, 32'h0123_3210);
    writeRule(3, 1, 2, 40'hF0_0000_0000, 32'h2121_0210);
    idle(2);

    curTag = "R1";
    sendReq(40'h0, 0);
    sendReq(40'h00_0FFF_FFFF, 0);
    sendReq(40'h00_1000_0000, 0);
    sendReq(40'h00_2000_0000, 0);
    sendReq(40'h00_3FFF_FFFF, 0);
    sendReq(40'hF0_0000_0000, 0);
    curTag = "R12";
    sendReq(40'hFF_FFFF_FFFF, 1);
    sendReq(rndIn(40'h00_1000_0000, 40'h00_2000_0000), 0);

    curTag = "R2";
    for (int i = 0; i < 16; i++) sendReq(rndIn(40'h0, 40'h00_1000_0000), i[0]);
    curTag = "R3";
    for (int i = 0; i < 16; i++) sendReq(rndIn(40'h00_2000_0000, 40'h00_4000_0000), i[0]);
    curTag = "R4";
    for (int i = 0; i < 40; i++) sendReq(rndIn(40'h00_4000_0000, 40'hF0_0000_0000), i[1]);
    for (int i = 0; i < 8; i++) sendReq(40'h00_4000_0000 + 40'(i * 64), 0);
    idle(3);

    curTag = "R5";
    writeRule(0, 1, 0, 40'h00_1000_0000, 32'hFEDC_BA98);
    for (int i = 0; i < 8; i++) sendReq(40'(i * 64), 0);
    curTag = "R6";
    writeRule(0, 1, 0, 40'h00_1000_0000, 32'h3321_1200);
    for (int i = 0; i < 8; i++) sendReq(40'(i * 64), 0);
    curTag = "R7";
    writeRule(0, 1, 0, 40'h00_1000_0000, 32'h0000_0000);
    sendReq(40'h40, 0);
    writeRule(0, 1, 0, 40'h00_1000_0000, 32'h2222_1111);
    sendReq(40'h80, 0);
    writeRule(0, 1, 0, 40'h00_1000_0000, 32'h0210_2102);
    sendReq(40'hC0, 0);
    writeRule(0, 1, 0, 40'h00_1000_0000, 32'h3210_3210);
    sendReq(40'h100, 0);

    curTag = "R8";
    for (int i = 0; i < 8; i++) begin sendReq(40'(i * 64), 0); sendReq(40'(i * 64), 1); end
    idle(3);
    chanMapRd = {3'd7, 3'd2, 3'd1, 3'd4};
    chanMapWr = {3'd1, 3'd0, 3'd4, 3'd2};
    idle(2);
    for (int i = 0; i < 8; i++) begin sendReq(40'(i * 64), 0); sendReq(40'(i * 64), 1); end
    idle(3);

    curTag = "R9";
    chanMapRd = {3'd3, 3'd3, 3'd3, 3'd3};
    chanMapWr = {3'd3, 3'd3, 3'd3, 3'd3};
    idle(2);
    for (int i = 0; i < 16; i++) sendReq(rndIn(40'h0, 40'h00_1000_0000), 0);
    for (int i = 0; i < 6; i++) sendReq(rndIn(40'h0, 40'h00_1000_0000), 1);
    sendReq(40'h00_0100_0000, 0);
    sendReq(40'h00_0100_1040, 0);
    idle(3);

    curTag = "R10";
    chanMapRd = {3'd6, 3'd5, 3'd6, 3'd5};
    chanMapWr = {3'd5, 3'd6, 3'd5, 3'd6};
    idle(2);
    for (int i = 0; i < 8; i++) begin sendReq(40'(i * 64), 0); sendReq(40'(i * 64), 1); end
    idle(3);

    curTag = "R11";
    lockstep = 1;
    idle(2);
    for (int i = 0; i < 8; i++) begin sendReq(40'(i * 64), i[0]); end
    for (int i = 0; i < 6; i++) sendReq(rndIn(40'h00_4000_0000, 40'hF0_0000_0000), 0);
    idle(3);
    lockstep = 0;
    idle(2);

    curTag = "R12";
    writeRule(1, 1, 3, 40'h00_2000_0000, 32'h3333_3333);
    for (int i = 0; i < 4; i++) sendReq(rndIn(40'h00_1000_0000, 40'h00_2000_0000), 0);

    curTag = "R13";
    fork
      writeRule(1, 1, 0, 40'h00_2000_0000, 32'h1230_1230);
      sendReq(40'h00_1000_0080, 0);
    join
    fork
      writeRule(1, 1, 2, 40'h00_2000_0000, 32'h0000_2222);
      sendReq(40'h00_1000_0040, 1);
    join
    for (int i = 0; i < 6; i++) sendReq(rndIn(40'h0, 40'hF0_0000_0000), i[0]);
    idle(6);
    finishRun();
  end

endmodule